// File: doc/BRIEF.md
# Guarded move instruction sequencer

This block sequences the single instruction of a 16-bit transport-triggered processor: a guarded move. Every instruction word is fetched from a shared memory whose reads destroy the stored word, so the sequencer writes the word straight back before it acts on it. It then decodes the word and drives a six-cycle sequence on a transport bus. The sequence reads a source location, optionally passes the value through an external modify unit, writes a destination location and restores the source, which also has destructive reads.

A literal form writes an 8-bit constant taken from the instruction word to the destination. A squash bit makes a move conditional on the outcome flag of the last executed move. The two move-control bits choose the order of the read, modify and write steps. The modify unit, the functional units behind the transport addresses and the address decoding all sit outside this block.

Top module: `mov_seq`

## Requirements
- R1: The instruction word is decoded as bit 15 = squash (Q), bit 14 = literal (L), bits 13:12 = move control (CC), bits 11:6 = source address, bits 5:0 = destination address; the transport address driven for a source access or a destination write is the matching 6-bit field.
- R2: Each instruction takes exactly six cycles, numbered 0 to 5. Cycle 0 reads memory at the program counter. Cycle 1 writes the word that was read back to the same memory address. The next instruction's cycle 0 follows cycle 5 directly.
- R3: When L=1 and the move is not squashed, no transport read, modify request or source restore occurs. In cycle 4 the destination receives {CC, source field} as an 8-bit value, zero-extended to 16 bits.
- R4: When Q=1 and the outcome flag is 1, cycles 2 to 5 carry no transport read, no transport write and no modify request, and the flag keeps its value. When Q=0 the move always executes.
- R5: CC=00 with L=0: transport read of the source in cycle 2, no activity in cycle 3, destination write of the read value in cycle 4, source restore with the read value in cycle 5.
- R6: CC=01 or CC=10 with L=0: source read in cycle 2, a modify request in cycle 3 with the read value as argument and type select 0 for CC=01 or 1 for CC=10, the modify result written to the destination in cycle 4, and the unmodified value restored to the source in cycle 5.
- R7: CC=11 with L=0: source read in cycle 2, the unmodified value written to the destination in cycle 3, a modify request with type select 0 in cycle 4, and the modify result written back to the source in cycle 5.
- R8: The outcome flag is 0 after reset. At the end of cycle 5 of an executed move it becomes 1 if the value written to the destination was nonzero, else 0. It changes at no other time.
- R9: The program counter resets to RESET_PC and increases by one at the end of cycle 1 of every instruction, squashed ones included.
- R10: Every destructive read is restored within the same instruction. The memory word comes back in cycle 1. The transport source comes back in cycle 5, at the same address, holding the read value, or the modified value under CC=11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | ADDR_W | Memory address, equal to the program counter |
| mem_rd_o | output | 1 | Memory read strobe (cycle 0) |
| mem_wr_o | output | 1 | Memory write strobe (cycle 1) |
| mem_wdata_o | output | DATA_W | Memory write data (restored instruction word) |
| mem_rdata_i | input | DATA_W | Memory read data, valid in the read cycle |
| tp_addr_o | output | 6 | Transport address for source or destination access |
| tp_rd_o | output | 1 | Transport read strobe |
| tp_wr_o | output | 1 | Transport write strobe |
| tp_wdata_o | output | DATA_W | Transport write data |
| tp_rdata_i | input | DATA_W | Transport read data, valid in the read cycle |
| mod_en_o | output | 1 | Modify request to the external unit |
| mod_sel_o | output | 1 | Modify type select (0 = type 1, 1 = type 2) |
| mod_arg_o | output | DATA_W | Value handed to the modify unit |
| mod_res_i | input | DATA_W | Result from the modify unit, same cycle |
| pc_o | output | ADDR_W | Program counter |
| flag_o | output | 1 | Outcome flag of the last executed move |

## Verification
The hardest state to reach from the ports is a squashed move, because the squash depends on the flag left behind by an earlier instruction. The program therefore places conditional moves and conditional literals right after moves whose written value is nonzero, and also right after moves that write zero, either from a zero literal or from a source that holds zero. This way the same Q=1 encoding is seen both skipped and executed. The memory and transport models in the bench clear a word whenever it is read, so a missing or wrong restore shows up in the final comparison against the reference contents. A self move, where source and destination are the same location, exercises the ordering of the write and the restore.

// File: rtl/mov_pkg.sv
package mov_pkg;
  localparam int OP_W  = 16;
  localparam int TA_W  = 6;
  localparam int LIT_W = 8;

  typedef enum logic [2:0] {
    PH_FETCH   = 3'd0,
    PH_OPWB    = 3'd1,
    PH_READ    = 3'd2,
    PH_STEP3   = 3'd3,
    PH_STEP4   = 3'd4,
    PH_RESTORE = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    CC_PLAIN = 2'b00,
    CC_MODA  = 2'b01,
    CC_MODB  = 2'b10,
    CC_WMOD  = 2'b11
  } ctl_e;

  typedef struct packed {
    logic            q;
    logic            lit;
    ctl_e            cc;
    logic [TA_W-1:0] src;
    logic [TA_W-1:0] dst;
  } opcode_t;

  typedef struct packed {
    logic tp_rd;
    logic dst_wr;
    logic use_lit;
    logic src_wb;
    logic wb_mod;
    logic mod_en;
    logic mod_sel;
  } ctl_t;

  function automatic phase_e next_phase(input phase_e p);
    case (p)
      PH_FETCH: return PH_OPWB;
      PH_OPWB:  return PH_READ;
      PH_READ:  return PH_STEP3;
      PH_STEP3: return PH_STEP4;
      PH_STEP4: return PH_RESTORE;
      default:  return PH_FETCH;
    endcase
  endfunction

  function automatic logic [LIT_W-1:0] lit_byte(input opcode_t op);
    return {op.cc, op.src};
  endfunction

  function automatic logic squashed(input opcode_t op, input logic flag);
    return op.q & flag;
  endfunction
endpackage

// File: rtl/mov_phase_ctr.sv
module mov_phase_ctr
  import mov_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase_o,
  output logic   last_o
);
  phase_e ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_FETCH;
    else        ph_q <= next_phase(ph_q);
  end

  assign phase_o = ph_q;
  assign last_o  = (ph_q == PH_RESTORE);
endmodule

// File: rtl/mov_decode.sv
module mov_decode
  import mov_pkg::*;
(
  input  phase_e  phase_i,
  input  opcode_t op_i,
  input  logic    flag_i,
  output ctl_t    ctl_o,
  output logic    squash_o
);
  logic active;
  assign squash_o = squashed(op_i, flag_i);
  assign active   = ~squash_o;

  always_comb begin
    ctl_o = '0;
    if (active) begin
      case (phase_i)
        PH_READ: ctl_o.tp_rd = ~op_i.lit;
        PH_STEP3: begin
          if (!op_i.lit) begin
            if (op_i.cc == CC_MODA || op_i.cc == CC_MODB) begin
              ctl_o.mod_en  = 1'b1;
              ctl_o.mod_sel = (op_i.cc == CC_MODB);
            end else if (op_i.cc == CC_WMOD) begin
              ctl_o.dst_wr = 1'b1;
            end
          end
        end
        PH_STEP4: begin
          if (op_i.lit) begin
            ctl_o.dst_wr  = 1'b1;
            ctl_o.use_lit = 1'b1;
          end else if (op_i.cc == CC_WMOD) begin
            ctl_o.mod_en  = 1'b1;
            ctl_o.mod_sel = 1'b0;
          end else begin
            ctl_o.dst_wr = 1'b1;
          end
        end
        PH_RESTORE: begin
          ctl_o.src_wb = ~op_i.lit;
          ctl_o.wb_mod = ~op_i.lit & (op_i.cc == CC_WMOD);
        end
        default: ctl_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mov_data.sv
module mov_data
  import mov_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl_i,
  input  logic              last_i,
  input  logic              squash_i,
  input  logic [LIT_W-1:0]  lit_i,
  input  logic [DATA_W-1:0] tp_rdata_i,
  input  logic [DATA_W-1:0] mod_res_i,
  output logic [DATA_W-1:0] tp_wdata_o,
  output logic [DATA_W-1:0] mod_arg_o,
  output logic              flag_o
);
  localparam int PAD_W = DATA_W - LIT_W;

  logic [DATA_W-1:0] orig_q, work_q, lit_ext, dst_val, wb_val;
  logic              pend_q, flag_q;

  assign lit_ext = {{PAD_W{1'b0}}, lit_i};
  assign dst_val = ctl_i.use_lit ? lit_ext : work_q;
  assign wb_val  = ctl_i.wb_mod ? work_q : orig_q;

  always_comb begin
    tp_wdata_o = '0;
    if (ctl_i.dst_wr)      tp_wdata_o = dst_val;
    else if (ctl_i.src_wb) tp_wdata_o = wb_val;
  end

  assign mod_arg_o = ctl_i.mod_en ? work_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orig_q <= '0;
      work_q <= '0;
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ctl_i.tp_rd) begin
        orig_q <= tp_rdata_i;
        work_q <= tp_rdata_i;
      end else if (ctl_i.mod_en) begin
        work_q <= mod_res_i;
      end
      if (ctl_i.dst_wr) pend_q <= |dst_val;
      if (last_i && !squash_i) flag_q <= pend_q;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/mov_seq.sv
module mov_seq
  import mov_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [TA_W-1:0]   tp_addr_o,
  output logic              tp_rd_o,
  output logic              tp_wr_o,
  output logic [DATA_W-1:0] tp_wdata_o,
  input  logic [DATA_W-1:0] tp_rdata_i,
  output logic              mod_en_o,
  output logic              mod_sel_o,
  output logic [DATA_W-1:0] mod_arg_o,
  input  logic [DATA_W-1:0] mod_res_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              flag_o
);
  phase_e            phase_w;
  logic              last_w, squash_w, flag_w;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  opcode_t           op_w;
  ctl_t              ctl_w;

  mov_phase_ctr u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase_o(phase_w),
    .last_o (last_w)
  );

  assign op_w = opcode_t'(ir_q[OP_W-1:0]);

  mov_decode u_dec (
    .phase_i (phase_w),
    .op_i    (op_w),
    .flag_i  (flag_w),
    .ctl_o   (ctl_w),
    .squash_o(squash_w)
  );

  mov_data #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_i     (ctl_w),
    .last_i    (last_w),
    .squash_i  (squash_w),
    .lit_i     (lit_byte(op_w)),
    .tp_rdata_i(tp_rdata_i),
    .mod_res_i (mod_res_i),
    .tp_wdata_o(tp_wdata_o),
    .mod_arg_o (mod_arg_o),
    .flag_o    (flag_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
      ir_q <= '0;
    end else begin
      if (phase_w == PH_FETCH) ir_q <= mem_rdata_i;
      if (phase_w == PH_OPWB)  pc_q <= pc_q + 1'b1;
    end
  end

  assign mem_addr_o  = pc_q;
  assign mem_rd_o    = (phase_w == PH_FETCH);
  assign mem_wr_o    = (phase_w == PH_OPWB);
  assign mem_wdata_o = mem_wr_o ? ir_q : '0;

  always_comb begin
    tp_addr_o = '0;
    if (ctl_w.tp_rd || ctl_w.src_wb) tp_addr_o = op_w.src;
    else if (ctl_w.dst_wr)           tp_addr_o = op_w.dst;
  end

  assign tp_rd_o   = ctl_w.tp_rd;
  assign tp_wr_o   = ctl_w.dst_wr | ctl_w.src_wb;
  assign mod_en_o  = ctl_w.mod_en;
  assign mod_sel_o = ctl_w.mod_sel;
  assign pc_o      = pc_q;
  assign flag_o    = flag_w;
endmodule

// File: rtl/mov_seq_chk.sv
module mov_seq_chk
  import mov_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic              tp_rd_o,
  input logic              tp_wr_o,
  input logic [TA_W-1:0]   tp_addr_o,
  input logic              mod_en_o,
  input logic              flag_o,
  input phase_e            phase_w,
  input logic              squash_w
);
  // R2 / R10: the fetched word is written back unchanged to the same address next cycle
  a_r2_opcode_restore: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> (mem_wr_o && mem_addr_o == $past(mem_addr_o)
                  && mem_wdata_o == $past(mem_rdata_i)));

  // R9: program counter steps by one after the write-back cycle
  a_r9_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> (pc_o == $past(pc_o) + 1'b1));

  // R4: a squashed move is silent on the transport bus and the modify hook
  a_r4_squash_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_w != PH_FETCH && phase_w != PH_OPWB && squash_w)
      |-> (!tp_rd_o && !tp_wr_o && !mod_en_o));

  // R8: the flag only moves at the end of the last cycle of an instruction
  a_r8_flag_timing: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flag_o) |-> ($past(phase_w) == PH_RESTORE));

  // R10: a transport read is restored at the same address three cycles later
  a_r10_source_restore: assert property (@(posedge clk) disable iff (!rst_n)
    tp_rd_o |-> ##3 (tp_wr_o && tp_addr_o == $past(tp_addr_o, 3)));

  // R6 / R7: a modify cycle carries no transport access
  a_r7_mod_alone: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en_o |-> (!tp_wr_o && !tp_rd_o));
endmodule

bind mov_seq mov_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_rdata_i(mem_rdata_i),
  .pc_o       (pc_o),
  .tp_rd_o    (tp_rd_o),
  .tp_wr_o    (tp_wr_o),
  .tp_addr_o  (tp_addr_o),
  .mod_en_o   (mod_en_o),
  .flag_o     (flag_o),
  .phase_w    (phase_w),
  .squash_w   (squash_w)
);

// File: tb/mov_seq_test.sv
`timescale 1ns/1ps
module mov_seq_test;
  localparam int NINSTR = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, tp_wdata, tp_rdata, mod_arg, mod_res, pc;
  logic        mem_rd, mem_wr, tp_rd, tp_wr, mod_en, mod_sel, flag;
  logic [5:0]  tp_addr;

  always #2 clk = ~clk;

  mov_seq uut (
    .clk(clk), .rst_n(rst_n),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .tp_addr_o(tp_addr), .tp_rd_o(tp_rd), .tp_wr_o(tp_wr),
    .tp_wdata_o(tp_wdata), .tp_rdata_i(tp_rdata),
    .mod_en_o(mod_en), .mod_sel_o(mod_sel), .mod_arg_o(mod_arg), .mod_res_i(mod_res),
    .pc_o(pc), .flag_o(flag)
  );

  // destructive environment: a read clears the cell
  logic [15:0] emem [256];
  logic [15:0] etp  [64];
  int gmem [256];
  int gtp  [64];

  assign mem_rdata = emem[mem_addr[7:0]];
  assign tp_rdata  = etp[tp_addr];
  assign mod_res   = mod_sel ? ~mod_arg : mod_arg + 16'd1;

  always @(posedge clk) if (rst_n) begin
    if (mem_rd) emem[mem_addr[7:0]] <= 16'd0;
    if (mem_wr) emem[mem_addr[7:0]] <= mem_wdata;
    if (tp_rd)  etp[tp_addr] <= 16'd0;
    if (tp_wr)  etp[tp_addr] <= tp_wdata;
  end

  int checks = 0, errors = 0;
  bit run = 0, done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int mv(int q, int cc, int s, int d);
    return q * 32768 + cc * 4096 + s * 64 + d;
  endfunction
  function automatic int lt(int q, int v, int d);
    return q * 32768 + 16384 + v * 64 + d;
  endfunction
  function automatic int modf(int v, int sel);
    return sel ? (~v) & 16'hFFFF : (v + 1) & 16'hFFFF;
  endfunction

  // behavioural reference model
  int m_ph = 0, m_pc = 0, m_flag = 0, m_pend = 0;
  int m_word, m_q, m_l, m_cc, m_s, m_d, m_lit, m_act, m_val, m_cur;
  int e_mrd, e_mwr, e_trd, e_twr, e_men, e_msel, e_marg, e_taddr, e_twd;
  string tag;

  always @(negedge clk) if (run) begin
    if (m_ph == 0) begin
      m_word = gmem[m_pc & 255];            // R1 field positions
      m_q   = (m_word >> 15) & 1;
      m_l   = (m_word >> 14) & 1;
      m_cc  = (m_word >> 12) & 3;
      m_s   = (m_word >> 6) & 63;
      m_d   = m_word & 63;
      m_lit = (m_word >> 6) & 255;
      m_act = !(m_q && m_flag);
    end
    e_mrd = 0; e_mwr = 0; e_trd = 0; e_twr = 0; e_men = 0;
    e_msel = 0; e_marg = 0; e_taddr = 0; e_twd = 0;
    if (m_ph < 2)       tag = "R2";
    else if (!m_act)    tag = "R4";
    else if (m_l != 0)  tag = "R3";
    else if (m_cc == 0) tag = "R5";
    else if (m_cc == 3) tag = "R7";
    else                tag = "R6";
    case (m_ph)
      0: e_mrd = 1;
      1: e_mwr = 1;
      2: if (m_act && !m_l) begin e_trd = 1; e_taddr = m_s; end
      3: if (m_act && !m_l) begin
           if (m_cc == 1 || m_cc == 2) begin e_men = 1; e_msel = (m_cc == 2); e_marg = m_cur; end
           else if (m_cc == 3) begin e_twr = 1; e_taddr = m_d; e_twd = m_val; end
         end
      4: if (m_act) begin
           if (m_l) begin e_twr = 1; e_taddr = m_d; e_twd = m_lit; end
           else if (m_cc == 3) begin e_men = 1; e_msel = 0; e_marg = m_cur; end
           else begin e_twr = 1; e_taddr = m_d; e_twd = m_cur; end
         end
      default: if (m_act && !m_l) begin
           e_twr = 1; e_taddr = m_s; e_twd = (m_cc == 3) ? m_cur : m_val;
         end
    endcase
    chk(mem_rd == e_mrd, "R2", "mem_rd", mem_rd, e_mrd);
    chk(mem_wr == e_mwr, "R2", "mem_wr", mem_wr, e_mwr);
    if (e_mrd || e_mwr) chk(int'(mem_addr) == m_pc, "R9", "mem_addr", mem_addr, m_pc);
    if (e_mwr) chk(int'(mem_wdata) == m_word, "R10", "opcode write-back", mem_wdata, m_word);
    chk(tp_rd == e_trd, tag, "tp_rd", tp_rd, e_trd);
    chk(tp_wr == e_twr, tag, "tp_wr", tp_wr, e_twr);
    if (e_trd || e_twr) chk(int'(tp_addr) == e_taddr, "R1", "tp_addr", tp_addr, e_taddr);
    if (e_twr) chk(int'(tp_wdata) == e_twd, tag, "tp_wdata", tp_wdata, e_twd);
    chk(mod_en == e_men, tag, "mod_en", mod_en, e_men);
    if (e_men) begin
      chk(mod_sel == e_msel, tag, "mod_sel", mod_sel, e_msel);
      chk(int'(mod_arg) == e_marg, tag, "mod_arg", mod_arg, e_marg);
    end
    chk(int'(pc) == m_pc, "R9", "pc", pc, m_pc);
    chk(flag == m_flag, "R8", "flag", flag, m_flag);
    // advance the model
    if (m_ph == 1) m_pc = (m_pc + 1) & 16'hFFFF;
    if (e_trd) begin m_val = gtp[m_s]; m_cur = m_val; end
    if (e_men) m_cur = modf(m_cur, e_msel);
    if (e_twr) begin
      gtp[e_taddr] = e_twd;
      if (e_taddr == m_d && !(m_ph == 5)) m_pend = (e_twd != 0);
    end
    if (m_ph == 5 && m_act) m_flag = m_pend;
    m_ph = (m_ph + 1) % 6;
  end

  int prog [NINSTR];

  initial begin
    prog[0]  = mv(0, 0, 5, 10);    // plain move, flag -> 1
    prog[1]  = mv(1, 0, 6, 11);    // squashed
    prog[2]  = lt(0, 8'h00, 12);   // zero literal, flag -> 0
    prog[3]  = lt(1, 8'hA5, 13);   // conditional literal runs
    prog[4]  = mv(0, 1, 7, 14);    // modify type 1
    prog[5]  = mv(0, 2, 8, 15);    // modify type 2
    prog[6]  = mv(0, 3, 9, 16);    // write then modify
    prog[7]  = lt(0, 8'hFF, 17);   // zero extension
    prog[8]  = mv(0, 0, 0, 18);    // zero source, flag -> 0
    prog[9]  = mv(1, 1, 20, 21);   // conditional move runs
    prog[10] = mv(0, 0, 22, 22);   // self move
    prog[11] = mv(1, 3, 2, 3);     // squashed
    prog[12] = lt(1, 8'h00, 30);   // squashed literal
    prog[13] = mv(0, 2, 31, 32);
    prog[14] = mv(1, 0, 33, 34);   // squashed
    prog[15] = mv(0, 3, 40, 41);
    for (int i = 0; i < 256; i++) begin
      gmem[i] = (i < NINSTR) ? prog[i] : 0;
      emem[i] = 16'(gmem[i]);
    end
    for (int i = 0; i < 64; i++) begin
      gtp[i] = (i == 0) ? 0 : ((i * 16'h0123) ^ 16'h5A00) & 16'hFFFF;
      etp[i] = 16'(gtp[i]);
    end
    repeat (4) @(negedge clk);
    chk(pc == 16'd0, "R9", "reset pc", pc, 0);
    chk(flag == 1'b0, "R8", "reset flag", flag, 0);
    chk(!mem_wr && !tp_wr, "R2", "writes in reset", {mem_wr, tp_wr}, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    run = 1'b1;
    repeat (NINSTR * 6) @(posedge clk);
    #1 run = 1'b0;
    chk(etp[17] == 16'h00FF, "R3", "zero-extended literal", etp[17], 16'h00FF);
    chk(etp[30] == 16'(gtp[30]), "R4", "squashed literal target", etp[30], gtp[30]);
    for (int i = 0; i < 64; i++)
      chk(int'(etp[i]) == gtp[i], "R10", $sformatf("transport cell %0d", i), etp[i], gtp[i]);
    for (int i = 0; i < 32; i++)
      chk(int'(emem[i]) == gmem[i], "R10", $sformatf("memory word %0d", i), emem[i], gmem[i]);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule